// File: doc/BRIEF.md
# Bi-phase Serial Word Transmitter

This block turns a stream of 12-bit data words into a single self-clocking serial line. Every bit occupies one bit cell: the line changes level at the start of each cell, and changes again halfway through the cell only when the bit is a 1. Words leave least significant bit first, back to back with no gap between them. The speed is set by a half-bit tick. The tick is divided down from the system clock, and a 4-bit code picks one of nine rates, each twice the one before it, from 384 bit/s up to 98304 bit/s. At every rate a word lasts exactly twelve bit periods.

Words are grouped into subframes of a parameterised number of word slots. Slot 0 of every subframe carries a sync pattern taken from a configuration input. Every other slot takes its word from an external transmit FIFO through an empty flag, a read strobe and a data bus, and the FIFO must show its head word without waiting for the strobe. If the FIFO has nothing to give when a slot begins, the block sends a word of zeros so that the bit stream never stops. Clearing the enable input brings the line back to a low idle level and rewinds to the start of a subframe.

Top module: `hbp_serial_tx`

## Requirements
- R1: While rst_n is low at a clock edge, line_out is 0 after that edge and fifo_rd stays 0.
- R2: After enable rises, the first line transition comes after exactly D clock edges, and further half-bit ticks follow every D cycles. D = (SYS_CLK_HZ / (2*BASE_BAUD)) >> k, where k is rate_sel for codes 0 to 8 and k is 8 for codes 9 to 15.
- R3: line_out toggles at the start of every bit cell. It toggles again at the middle of the cell if the bit is 1 and holds if the bit is 0. It never changes at any other time while enable is high.
- R4: Each word is sent as 12 consecutive bit cells, bit 0 first and bit 11 last. The next word follows with no idle cell.
- R5: Word slot 0 of each subframe of SUBFRAME_WORDS slots sends sync_word as it stands when the slot begins, and no FIFO read happens for that slot.
- R6: At the first edge of any other slot, if fifo_empty is low, fifo_rd is high for exactly that one cycle and the word on fifo_rdata is sent. fifo_rd is never high while fifo_empty is high.
- R7: If fifo_empty is high when a non-sync slot begins, a word of all zeros is sent in that slot and no read is made.
- R8: While enable is low, line_out is 0 and fifo_rd is 0. The next rise of enable starts a new subframe with the sync word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Runs the transmitter; low forces idle and rewinds |
| rate_sel | input | 4 | Rate code, 0 (slowest) to 8 (fastest); higher codes act as 8 |
| sync_word | input | 12 | Pattern sent in slot 0 of every subframe |
| fifo_empty | input | 1 | Transmit FIFO has no word |
| fifo_rdata | input | 12 | Head word of the transmit FIFO, shown before the read strobe |
| fifo_rd | output | 1 | One-cycle pop strobe to the transmit FIFO |
| line_out | output | 1 | Bi-phase coded serial line |

## Verification
The bench targets the slowest, a middle and the fastest rate, along with an out-of-range code. At the fastest rate a tick fires on every cycle. A divider that is off by one, or that fails to clamp the high codes, shows up as a wrong delay before the first line transition. A one-bit sync word reveals the bit order: sending the most significant bit first moves its mid-cell transition to the end of the word. Runs with a short subframe and a FIFO that drains part way through check three things. A sync slot that pops the FIFO loses a data word. An empty slot that reads anyway, or sends stale bits, breaks the cycle-by-cycle line comparison. A disable that does not rewind starts the next run in the middle of a word.

// File: rtl/hbp_tx_pkg.sv
// Shared constants and types for the bi-phase serial transmitter.
package hbp_tx_pkg;
    localparam int WORD_W    = 12;  // bits per line word
    localparam int RATE_W    = 4;   // width of the rate code
    localparam int NUM_RATES = 9;   // selectable rates, each double the last

    // Where the word of the current slot comes from.
    typedef enum logic [1:0] {
        SRC_SYNC = 2'd0,
        SRC_FIFO = 2'd1,
        SRC_FILL = 2'd2
    } word_src_e;
endpackage

// File: rtl/hbp_baud_gen.sv
// Half-bit tick generator.
// Divides clk by BASE_DIV >> code, where code is rate_sel clamped to
// NUM_RATES-1. Produces a one-cycle tick at the end of every half bit cell.
// Assumes rate_sel is held steady while enable is high, and that BASE_DIV
// is at least 2**(NUM_RATES-1), so that every rate has a divisor of 1 or more.
module hbp_baud_gen #(
    parameter int BASE_DIV  = 162760,
    parameter int NUM_RATES = 9,
    parameter int RATE_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              half_tick
);
    localparam int CNT_W = $clog2(BASE_DIV + 1);
    localparam logic [RATE_W-1:0] TOP_CODE = RATE_W'(NUM_RATES - 1);

    logic [CNT_W-1:0] div_tab [NUM_RATES];
    logic [RATE_W-1:0] code_eff;
    logic [CNT_W-1:0]  div_sel;
    logic [CNT_W-1:0]  cnt;

    // One divisor per rate, halving at each step and never below 1.
    for (genvar k = 0; k < NUM_RATES; k++) begin : g_div
        localparam int DIV_K = ((BASE_DIV >> k) < 1) ? 1 : (BASE_DIV >> k);
        assign div_tab[k] = CNT_W'(DIV_K);
    end

    // Clamp out-of-range codes to the fastest rate.
    always_comb begin
        code_eff = (rate_sel > TOP_CODE) ? TOP_CODE : rate_sel;
        div_sel  = div_tab[code_eff];
    end

    assign half_tick = enable && (cnt >= div_sel - 1'b1);

    // Count clocks within a half bit cell; restart while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt <= '0;
        end else if (half_tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2: at any divisor above one, two ticks never come back to back
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (half_tick && (div_sel > 1)) |=> !half_tick);
endmodule

// File: rtl/hbp_bit_encoder.sv
// Bi-phase bit encoder.
// Counts half cells and bit positions, loads a word at the first tick of each
// word, and moves it out least significant bit first. The line toggles at
// every cell start and again at mid-cell for a 1. Assumes load_word is valid
// in the cycle where word_start is high.
module hbp_bit_encoder #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              half_tick,
    input  logic [WORD_W-1:0] load_word,
    output logic              word_start,
    output logic              word_done,
    output logic              line_out
);
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    logic              mid_q;    // next tick is the mid-cell tick
    logic [BIT_W-1:0]  bit_idx;
    logic [WORD_W-1:0] shreg;

    assign word_start = half_tick && !mid_q && (bit_idx == '0);
    assign word_done  = half_tick &&  mid_q && (bit_idx == LAST_BIT);

    // Drive the line and step through half cells and bit positions.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            line_out <= 1'b0;
            mid_q    <= 1'b0;
            bit_idx  <= '0;
            shreg    <= '0;
        end else if (half_tick) begin
            if (!mid_q) begin
                line_out <= ~line_out;
                mid_q    <= 1'b1;
                if (bit_idx == '0) begin
                    shreg <= load_word;
                end
            end else begin
                if (shreg[0]) begin
                    line_out <= ~line_out;
                end
                shreg   <= shreg >> 1;
                mid_q   <= 1'b0;
                bit_idx <= (bit_idx == LAST_BIT) ? '0 : bit_idx + 1'b1;
            end
        end
    end

    // R8: a low enable leaves the line at the idle level
    a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !line_out);

    // R3: without a tick the line holds while running
    a_r3_edge_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !half_tick) |=> $stable(line_out));
endmodule

// File: rtl/hbp_word_sched.sv
// Word slot scheduler.
// Tracks the slot within a subframe and picks the word for each slot: the
// sync pattern in slot 0, the FIFO head word otherwise, or zeros when the
// FIFO is empty. The FIFO must show its head word before the pop strobe.
module hbp_word_sched #(
    parameter int WORD_W         = 12,
    parameter int SUBFRAME_WORDS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              word_start,
    input  logic              word_done,
    input  logic [WORD_W-1:0] sync_word,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_rdata,
    output logic              fifo_rd,
    output logic [WORD_W-1:0] next_word
);
    import hbp_tx_pkg::*;

    localparam int SLOT_W = (SUBFRAME_WORDS > 1) ? $clog2(SUBFRAME_WORDS) : 1;
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SUBFRAME_WORDS - 1);

    logic [SLOT_W-1:0] slot;
    word_src_e         src;

    // Pick the word source for the current slot.
    always_comb begin
        if (slot == '0) begin
            src       = SRC_SYNC;
            next_word = sync_word;
        end else if (!fifo_empty) begin
            src       = SRC_FIFO;
            next_word = fifo_rdata;
        end else begin
            src       = SRC_FILL;
            next_word = '0;
        end
    end

    assign fifo_rd = word_start && (src == SRC_FIFO);

    // Advance the slot count at the end of each word; rewind while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            slot <= '0;
        end else if (word_done) begin
            slot <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
        end
    end

    // R6: a slot pops the FIFO at most once
    a_r6_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd && !word_done) |=> !fifo_rd);
endmodule

// File: rtl/hbp_serial_tx.sv
// Bi-phase serial word transmitter, top level.
// Connects the rate divider, the slot scheduler and the bit encoder.
// Assumes a first-word-fall-through transmit FIFO, and that rate_sel and
// sync_word only change while enable is low.
module hbp_serial_tx #(
    parameter int SYS_CLK_HZ     = 125_000_000,
    parameter int BASE_BAUD      = 384,
    parameter int SUBFRAME_WORDS = 64
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               enable,
    input  logic [hbp_tx_pkg::RATE_W-1:0]      rate_sel,
    input  logic [hbp_tx_pkg::WORD_W-1:0]      sync_word,
    input  logic                               fifo_empty,
    input  logic [hbp_tx_pkg::WORD_W-1:0]      fifo_rdata,
    output logic                               fifo_rd,
    output logic                               line_out
);
    import hbp_tx_pkg::*;

    localparam int BASE_DIV = SYS_CLK_HZ / (2 * BASE_BAUD);

    logic              half_tick;
    logic              word_start;
    logic              word_done;
    logic [WORD_W-1:0] next_word;

    hbp_baud_gen #(
        .BASE_DIV (BASE_DIV),
        .NUM_RATES(NUM_RATES),
        .RATE_W   (RATE_W)
    ) baud_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .rate_sel (rate_sel),
        .half_tick(half_tick)
    );

    hbp_word_sched #(
        .WORD_W        (WORD_W),
        .SUBFRAME_WORDS(SUBFRAME_WORDS)
    ) sched_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .word_start(word_start),
        .word_done (word_done),
        .sync_word (sync_word),
        .fifo_empty(fifo_empty),
        .fifo_rdata(fifo_rdata),
        .fifo_rd   (fifo_rd),
        .next_word (next_word)
    );

    hbp_bit_encoder #(
        .WORD_W(WORD_W)
    ) enc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .half_tick (half_tick),
        .load_word (next_word),
        .word_start(word_start),
        .word_done (word_done),
        .line_out  (line_out)
    );

    // R6: never pop an empty FIFO
    a_r6_read_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty);
endmodule

// File: tb/hbp_serial_tx_tb.sv
`timescale 1ns/1ps
// Bench for hbp_serial_tx: a behavioural FIFO and line model, compared on every clock.
module hbp_serial_tx_tb_top;
    localparam int SYS_HZ = 196608;   // gives a base half-bit divisor of 256
    localparam int BASE   = 256;
    localparam int SF     = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [3:0]  rate_sel = 4'd8;
    logic [11:0] sync_word = 12'h000;
    logic        fifo_empty = 1'b1;
    logic [11:0] fifo_rdata = 12'h000;
    logic        fifo_rd;
    logic        line_out;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [11:0] q[$];

    // model state
    int          m_cnt = 0, m_half = 0, m_bit = 0, m_word = 0, m_kind = 0;
    logic [11:0] m_sh = '0;
    logic        m_line = 1'b0, m_rd = 1'b0, prev_rd = 1'b0;
    bit          cmp_on = 1'b0;

    always #4 clk = ~clk;

    hbp_serial_tx #(.SYS_CLK_HZ(SYS_HZ), .BASE_BAUD(384), .SUBFRAME_WORDS(SF)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rate_sel(rate_sel),
        .sync_word(sync_word), .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata),
        .fifo_rd(fifo_rd), .line_out(line_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: advance one clock from the requirements.
    always @(posedge clk) begin
        int div;
        m_rd = 1'b0;
        if (!rst_n || !enable) begin
            m_cnt = 0; m_half = 0; m_bit = 0; m_word = 0; m_line = 1'b0; m_sh = '0;
        end else begin
            div = BASE >> ((rate_sel > 8) ? 8 : rate_sel);
            if (m_cnt == div - 1) begin
                m_cnt = 0;
                if (m_half == 0) begin
                    m_line = ~m_line;
                    if (m_bit == 0) begin
                        if (m_word == 0) begin
                            m_sh = sync_word; m_kind = 0;
                        end else if (q.size() > 0) begin
                            m_sh = q.pop_front(); m_rd = 1'b1; m_kind = 1;
                        end else begin
                            m_sh = '0; m_kind = 2;
                        end
                    end
                    m_half = 1;
                end else begin
                    if (m_sh[0]) m_line = ~m_line;
                    m_sh = m_sh >> 1;
                    m_half = 0;
                    if (m_bit == 11) begin
                        m_bit = 0;
                        m_word = (m_word + 1) % SF;
                    end else begin
                        m_bit++;
                    end
                end
            end else begin
                m_cnt++;
            end
        end
    end

    // Off-edge: compare against the model, then present the FIFO head.
    always begin
        @(negedge clk);
        #1;
        if (cmp_on) begin
            check(line_out == m_line,
                  (m_kind == 0) ? "R5 line (sync slot)" :
                  (m_kind == 2) ? "R7 line (filler slot)" : "R3 line (data slot)",
                  line_out, m_line);
            check(prev_rd == m_rd, "R6 fifo_rd", prev_rd, m_rd);
        end
        prev_rd    = fifo_rd;
        fifo_empty = (q.size() == 0);
        fifo_rdata = (q.size() > 0) ? q[0] : 12'h000;
    end

    // Start at a rate and count cycles until the first line transition.
    task automatic start_measure(input logic [3:0] rate, input logic [11:0] sw, input int exp_div);
        int n;
        @(negedge clk);
        rate_sel = rate; sync_word = sw; enable = 1'b1;
        n = 0;
        do begin
            @(negedge clk); #2; n++;
        end while (!line_out && n < 2000);
        check(n == exp_div, "R2 first transition delay", n, exp_div);
    endtask

    task automatic stop_and_idle();
        int sz;
        @(negedge clk);
        enable = 1'b0;
        sz = q.size();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); #2;
            check(line_out == 1'b0, "R8 idle line", line_out, 0);
            check(fifo_rd == 1'b0, "R8 no read while idle", fifo_rd, 0);
        end
        check(q.size() == sz, "R8 FIFO untouched while idle", q.size(), sz);
    endtask

    initial begin
        logic [3:0] seq;
        // R1: reset state, with a word waiting in the FIFO
        q.push_back(12'h3C5);
        repeat (4) @(negedge clk);
        #2;
        check(line_out == 1'b0, "R1 line in reset", line_out, 0);
        check(fifo_rd == 1'b0, "R1 no read in reset", fifo_rd, 0);
        @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        q.delete();
        @(negedge clk);

        // Fastest rate, one-bit sync word: R4 bit order, then a data run.
        q.push_back(12'hABC); q.push_back(12'h555); q.push_back(12'h0F0);
        q.push_back(12'hFFF); q.push_back(12'h801);
        @(negedge clk);
        rate_sel = 4'd8; sync_word = 12'h001; enable = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #2;
            seq[i] = line_out;
        end
        check(seq == 4'b1101, "R4 LSB first (levels 1,0,1,1)", seq, 4'b1101);
        repeat (200) @(negedge clk);
        check(q.size() == 0, "R6 all data words consumed", q.size(), 0);
        stop_and_idle();

        // Middle rate, R8: no reads while disabled, restart with sync.
        q.push_back(12'h123); q.push_back(12'hFED); q.push_back(12'h7A7);
        repeat (20) @(negedge clk);
        check(q.size() == 3, "R8 no pop before enable", q.size(), 3);
        start_measure(4'd5, 12'hA5C, 8);
        repeat (4000) @(negedge clk);
        stop_and_idle();

        // Slowest rate: sync slot must not pop, next slot pops once.
        q.push_back(12'h00F); q.push_back(12'hC33);
        @(negedge clk);
        start_measure(4'd0, 12'h5A5, 256);
        repeat (5600) @(negedge clk);
        check(q.size() == 2, "R5 sync slot does not read FIFO", q.size(), 2);
        repeat (1000) @(negedge clk);
        check(q.size() == 1, "R6 one pop for slot 1", q.size(), 1);
        stop_and_idle();
        q.delete();

        // Out-of-range code clamps to the fastest rate; empty FIFO gives fillers.
        start_measure(4'd12, 12'hF00, 1);
        repeat (150) @(negedge clk);
        stop_and_idle();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1600000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule